// File: doc/BRIEF.md
# Presettable Binary Up-Counter with Two Count Enables

This block is a synchronous binary up-counter, four bits wide by default, that can be preset from a parallel data input. It can be cleared synchronously and counts only when two separate enables are both high. Each rising clock edge applies one action. A clear comes first, then a preset, then a count step. If none of these applies, the value holds. When the counter steps from the all-ones value it wraps to zero without help.

A terminal-count output lets stages be chained into a wider counter. It is high while the value is all ones and the second enable is high. The first enable does not affect it. To chain stages, tie the first enable of every stage to a common count request. Feed each stage's terminal-count output into the second enable of the next stage. The stages then step together as one wide binary counter.

An asynchronous active-low reset sets the value to zero at once. The reset is meant to be released in step with the clock.

Top module: `presettable_counter`

## Requirements
- R1: While `rst_n` is low the value is zero at once, without waiting for a clock edge.
- R2: On a rising edge with `clr_n` low, the value becomes zero, whatever `load_n`, `en_p` and `en_t` are.
- R3: On a rising edge with `clr_n` high and `load_n` low, the value takes `din`, with either enable at any level.
- R4: On a rising edge with `clr_n` and `load_n` high and both `en_p` and `en_t` high, the value increases by one.
- R5: On a rising edge with `clr_n` and `load_n` high and either enable low, the value is unchanged.
- R6: A count step from the all-ones value (1111 at the default width) gives zero.
- R7: `carry` is high exactly when the value is all ones and `en_t` is high, independent of `en_p`. It follows these inputs with no clock delay.
- R8: Pulling `clr_n` low does not change the value before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low clear |
| load_n | input | 1 | Synchronous active-low preset from `din` |
| en_p | input | 1 | Count enable, local to this stage |
| en_t | input | 1 | Count enable that also gates `carry` |
| din | input | WIDTH | Preset value |
| count | output | WIDTH | Current counter value |
| carry | output | 1 | Terminal-count output for chaining |

## Verification
Clear, preset, count and hold each change `count` exactly one rising edge after the controls are applied. The bench drives the controls at the falling edge and reads `count` a short delay after the next rising edge. `carry` is combinational from the value and `en_t`, so it is read in the same window and compared against the `en_t` level then applied. The reset takes effect at once, and an asserted clear takes effect only at the edge. These are checked by sampling a nanosecond after the input moves, before any edge follows, and then again after the edge.

// File: rtl/presettable_counter_pkg.sv
package presettable_counter_pkg;

  // Action selected for the coming clock edge, in priority order.
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } cnt_mode_e;

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import presettable_counter_pkg::*;
(
  input  logic      clr_n,
  input  logic      load_n,
  input  logic      en_p,
  input  logic      en_t,
  output cnt_mode_e mode
);

  // Clear beats preset, preset beats counting, counting needs both enables.
  always_comb begin
    if (!clr_n) begin
      mode = MODE_CLEAR;
    end else if (!load_n) begin
      mode = MODE_LOAD;
    end else if (en_p && en_t) begin
      mode = MODE_COUNT;
    end else begin
      mode = MODE_HOLD;
    end
  end

endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import presettable_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_mode_e        mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt,
  output logic             upd,
  output logic             all_ones
);

  localparam int CHAIN = WIDTH + 1;

  logic [CHAIN-1:0] ones_below;
  logic [WIDTH-1:0] incr;

  assign ones_below[0] = 1'b1;

  // Each bit flips when every bit below it is one; the chain end flags all ones.
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign ones_below[gi+1] = ones_below[gi] & cur[gi];
      assign incr[gi]         = cur[gi] ^ ones_below[gi];
    end
  endgenerate

  assign all_ones = ones_below[WIDTH];

  always_comb begin
    unique case (mode)
      MODE_CLEAR: nxt = '0;
      MODE_LOAD:  nxt = din;
      MODE_COUNT: nxt = incr;
      default:    nxt = cur;
    endcase
  end

  assign upd = (mode != MODE_HOLD);

endmodule

// File: rtl/cnt_reg.sv
module cnt_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import presettable_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             carry
);

  cnt_mode_e        mode;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;
  logic             term;

  cnt_ctrl u_ctrl (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .mode   (mode)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .mode     (mode),
    .cur      (cnt_q),
    .din      (din),
    .nxt      (cnt_d),
    .upd      (cnt_en),
    .all_ones (term)
  );

  cnt_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cnt_en),
    .d     (cnt_d),
    .q     (cnt_q)
  );

  assign count = cnt_q;
  assign carry = term & en_t;

endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] count,
  input logic             carry
);

  localparam logic [WIDTH-1:0] TOP = '1;

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> count == '0);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> count == '0);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> count == $past(din));

  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && en_p && en_t) |=> count == WIDTH'($past(count) + 1'b1));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(count));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && en_p && en_t && count == TOP) |=> count == '0);

  p_carry_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && en_t) |-> carry);

  p_carry_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count != TOP || !en_t) |-> !carry);

endmodule

bind presettable_counter presettable_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clr_n  (clr_n),
  .load_n (load_n),
  .en_p   (en_p),
  .en_t   (en_t),
  .din    (din),
  .count  (count),
  .carry  (carry)
);

// File: tb/presettable_counter_test.sv
`timescale 1ns/1ps
module presettable_counter_test;

  localparam int W = 4;
  localparam int NV = 12;

  // Vector layout: {clr_n, load_n, en_p, en_t, din[3:0], exp_count[3:0], exp_carry}
  localparam logic [12:0] VEC [NV] = '{
    {4'b1011, 4'd5,  4'd5,  1'b0},  // R3 preset overrides counting
    {4'b1111, 4'd0,  4'd6,  1'b0},  // R4 count step
    {4'b1101, 4'd0,  4'd6,  1'b0},  // R5 hold, en_p low
    {4'b1110, 4'd0,  4'd6,  1'b0},  // R5 hold, en_t low
    {4'b0011, 4'd9,  4'd0,  1'b0},  // R2 clear beats preset
    {4'b1000, 4'd14, 4'd14, 1'b0},  // R3 preset with enables low
    {4'b1111, 4'd0,  4'd15, 1'b1},  // R4/R7 reach all ones, carry up
    {4'b1101, 4'd0,  4'd15, 1'b1},  // R7 carry ignores en_p
    {4'b1110, 4'd0,  4'd15, 1'b0},  // R7 carry gated by en_t
    {4'b1111, 4'd0,  4'd0,  1'b0},  // R6 wrap to zero
    {4'b1001, 4'd15, 4'd15, 1'b1},  // R3/R7 preset to all ones
    {4'b0111, 4'd3,  4'd0,  1'b0}   // R2 clear from all ones
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clr_n, load_n, en_p, en_t;
  logic [W-1:0] din;
  logic [W-1:0] count;
  logic         carry;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  presettable_counter #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t), .din(din), .count(count), .carry(carry)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic p, input logic t,
                       input logic [W-1:0] d);
    @(negedge clk);
    clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0; din = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset value", count, 0);
    check("R7 carry in reset", carry, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
      check($sformatf("R2-table vector %0d count", i), count, VEC[i][4:1]);
      check($sformatf("R7 vector %0d carry", i), carry, VEC[i][0]);
    end

    // R6 and R4: full cycle from zero, carry only at all ones
    drive(1'b1, 1'b0, 1'b0, 1'b1, 4'd0);
    for (int k = 1; k <= 17; k++) begin
      drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
      check("R4 R6 sweep count", count, k % 16);
      check("R7 sweep carry", carry, (k % 16) == 15 ? 1 : 0);
    end

    // R7: carry reacts to en_t with no clock edge in between
    drive(1'b1, 1'b0, 1'b0, 1'b1, 4'd15);
    @(negedge clk);
    clr_n = 1'b1; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
    #1;
    check("R7 carry drops with en_t", carry, 0);
    en_t = 1'b1;
    #1;
    check("R7 carry rises with en_t", carry, 1);

    // R8: clear waits for the edge
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd10);
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    check("R8 clear before edge", count, 10);
    @(posedge clk);
    #2;
    check("R2 clear at edge", count, 0);

    // R1: reset acts between edges
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd7);
    @(negedge clk);
    clr_n = 1'b1; load_n = 1'b1;
    #1;
    rst_n = 1'b0;
    #1;
    check("R1 async reset", count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 1'b1, 4'd0);
    check("R5 hold after reset", count, 0);

    finish_run();
  end

endmodule